// File: doc/BRIEF.md
# Touch Sample Frame Filter

This block turns a stream of packed touch-panel sample words into one report per frame. A frame is up to four words. Each word carries a raw 10-bit X coordinate, a raw 10-bit Y coordinate and a pen-level bit. The block inverts both raw coordinates (all-ones minus the raw value). When a frame closes with all four samples present and the fourth sample still shows the pen down, the block reports the truncated mean of the inverted second and third samples as a touch. Any other closed frame produces a pen-up report.

The input is a valid/ready word stream. A flush strobe closes a short frame when the upstream sample queue has run dry. An overrun strobe throws away the frame in progress. The output is a one-cycle report pulse with X, Y and a touch flag. The coordinates stay unchanged between touch reports.

Top module: `touch_frame_filter`

## Requirements
- R1: While reset is high and on the first cycle after it, `rpt_valid`, `rpt_touch`, `rpt_x` and `rpt_y` are all 0, and the frame in progress is empty.
- R2: X is taken from word bits [25:16] and Y from bits [9:0], each inverted as 1023 minus the raw value. A touch report carries floor((inv2 + inv3) / 2) for each axis, where inv2 and inv3 are the inverted values of the second and third words of the frame.
- R3: When the fourth word of a frame is accepted with bit 31 = 0 (pen down), `rpt_valid` is 1 with `rpt_touch` = 1 on the next cycle, and a new frame begins.
- R4: When the fourth word is accepted with bit 31 = 1 (pen up), the next cycle shows `rpt_valid` = 1 with `rpt_touch` = 0, and `rpt_x`/`rpt_y` keep their previous values.
- R5: `in_flush` with fewer than four words collected gives a pen-up report on the next cycle, with the coordinates held, and empties the frame. This includes a frame with zero words.
- R6: `in_overrun` empties the frame, drops any word offered in the same cycle, and gives no report on the next cycle, even when `in_flush` is also high. The following words start a fresh frame.
- R7: `rpt_valid` is high for exactly the cycle that follows a frame closing. `rpt_x` and `rpt_y` change only in a cycle where `rpt_valid` and `rpt_touch` are both 1.
- R8: `in_ready` is always 1 out of reset, so one word is accepted on every cycle that `in_valid` is high, including back to back.
- R9: Bit 31 of the first three words, and word bits [30:26] and [15:10], have no effect on any report.
- R10: A word and `in_flush` in the same cycle: the word joins the frame first. If it is the fourth word, the frame gives its normal report. Otherwise the frame gives a pen-up report. Either way there is exactly one report.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample word valid |
| in_ready | output | 1 | Sample word accepted (always 1) |
| in_word | input | 32 | Packed sample: [31] pen up, [25:16] raw X, [9:0] raw Y |
| in_flush | input | 1 | Close the current frame early |
| in_overrun | input | 1 | Discard the current frame |
| rpt_valid | output | 1 | One-cycle report strobe |
| rpt_touch | output | 1 | 1 = touch with position, 0 = pen up |
| rpt_x | output | 10 | Inverted, averaged X |
| rpt_y | output | 10 | Inverted, averaged Y |

## Verification
The bench builds the block with its default parameters: 10-bit coordinates, a 32-bit word, four-sample frames, and averaging of the second and third samples. At these values the bench can hand-compute extreme coordinates (0 and 1023), which exercise the carry into the sum's extra bit and the truncation. It can also reach every frame length from zero to four within a few cycles. A random phase then mixes gaps, flushes and overruns at every frame position, and compares each cycle against a queue-based model.

// File: rtl/touch_frame_filter.sv
module touch_frame_filter #(
  parameter int COORD_W   = 10,
  parameter int WORD_W    = 32,
  parameter int X_LSB     = 16,
  parameter int Y_LSB     = 0,
  parameter int PEN_BIT   = 31,
  parameter int FRAME_LEN = 4,
  parameter int MID_FIRST = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [WORD_W-1:0]  in_word,
  input  logic               in_flush,
  input  logic               in_overrun,
  output logic               rpt_valid,
  output logic               rpt_touch,
  output logic [COORD_W-1:0] rpt_x,
  output logic [COORD_W-1:0] rpt_y
);
  localparam int CNT_W      = $clog2(FRAME_LEN + 1);
  localparam int SUM_W      = COORD_W + 1;
  localparam int MID_SECOND = MID_FIRST + 1;

  logic [CNT_W-1:0] cnt;
  logic [SUM_W-1:0] sum_x, sum_y;

  assign in_ready = 1'b1;

  wire               take     = in_valid && in_ready && !in_overrun;
  wire [COORD_W-1:0] inv_x    = ~in_word[X_LSB +: COORD_W];
  wire [COORD_W-1:0] inv_y    = ~in_word[Y_LSB +: COORD_W];
  wire               is_mid   = take && (cnt == CNT_W'(MID_FIRST) || cnt == CNT_W'(MID_SECOND));
  wire               full     = take && (cnt == CNT_W'(FRAME_LEN - 1));
  wire               close    = !in_overrun && (full || in_flush);
  wire               pen_down = !in_word[PEN_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      sum_x     <= '0;
      sum_y     <= '0;
      rpt_valid <= 1'b0;
      rpt_touch <= 1'b0;
      rpt_x     <= '0;
      rpt_y     <= '0;
    end else begin
      rpt_valid <= close;
      if (in_overrun || close) begin
        cnt   <= '0;
        sum_x <= '0;
        sum_y <= '0;
      end else begin
        if (take) cnt <= cnt + CNT_W'(1);
        if (is_mid) begin
          sum_x <= sum_x + SUM_W'(inv_x);
          sum_y <= sum_y + SUM_W'(inv_y);
        end
      end
      if (close) begin
        rpt_touch <= full && pen_down;
        if (full && pen_down) begin
          rpt_x <= sum_x[SUM_W-1:1];
          rpt_y <= sum_y[SUM_W-1:1];
        end
      end
    end
  end
endmodule

module touch_frame_filter_chk #(
  parameter int COORD_W = 10,
  parameter int WORD_W  = 32,
  parameter int PEN_BIT = 31
) (
  input logic               clk,
  input logic               rst,
  input logic               in_valid,
  input logic               in_ready,
  input logic [WORD_W-1:0]  in_word,
  input logic               in_flush,
  input logic               in_overrun,
  input logic               rpt_valid,
  input logic               rpt_touch,
  input logic [COORD_W-1:0] rpt_x,
  input logic [COORD_W-1:0] rpt_y
);
  // R6
  overrun_no_report_chk: assert property (@(posedge clk) disable iff (rst)
    in_overrun |=> !rpt_valid);
  // R7
  report_has_cause_chk: assert property (@(posedge clk) disable iff (rst)
    rpt_valid |-> $past(in_valid || in_flush) && !$past(in_overrun));
  // R7
  coords_hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !(rpt_valid && rpt_touch) |-> $stable(rpt_x) && $stable(rpt_y));
  // R3
  touch_needs_pen_down_chk: assert property (@(posedge clk) disable iff (rst)
    rpt_valid && rpt_touch |-> $past(in_valid && !in_word[PEN_BIT]));
  // R8
  ready_high_chk: assert property (@(posedge clk) disable iff (rst)
    in_ready);
endmodule

bind touch_frame_filter touch_frame_filter_chk #(
  .COORD_W(COORD_W), .WORD_W(WORD_W), .PEN_BIT(PEN_BIT)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .in_word(in_word), .in_flush(in_flush), .in_overrun(in_overrun),
  .rpt_valid(rpt_valid), .rpt_touch(rpt_touch), .rpt_x(rpt_x), .rpt_y(rpt_y)
);

// File: tb/tb_touch_frame_filter.sv
module tb_touch_frame_filter;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_flush = 1'b0, in_overrun = 1'b0;
  logic [31:0] in_word = '0;
  logic in_ready, rpt_valid, rpt_touch;
  logic [9:0] rpt_x, rpt_y;
  int checks = 0, errors = 0;
  bit done = 0;
  string tag = "R1";

  always #2 clk = ~clk;

  touch_frame_filter dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .in_flush(in_flush), .in_overrun(in_overrun),
    .rpt_valid(rpt_valid), .rpt_touch(rpt_touch), .rpt_x(rpt_x), .rpt_y(rpt_y)
  );

  // behavioural reference
  logic [31:0] q[$];
  bit e_v, e_t;
  int e_x, e_y;
  always @(posedge clk) begin
    if (rst) begin
      q.delete(); e_v = 0; e_t = 0; e_x = 0; e_y = 0;
    end else begin
      e_v = 0;
      if (in_overrun) q.delete();
      else begin
        if (in_valid) q.push_back(in_word);
        if (q.size() == 4 || in_flush) begin
          e_v = 1;
          e_t = (q.size() == 4) && !q[3][31];
          if (e_t) begin
            e_x = ((1023 - int'(q[1][25:16])) + (1023 - int'(q[2][25:16]))) / 2;
            e_y = ((1023 - int'(q[1][9:0])) + (1023 - int'(q[2][9:0]))) / 2;
          end
          q.delete();
        end
      end
    end
  end

  always @(negedge clk) if (!done) begin
    checks++;
    if (rpt_valid !== e_v || rpt_touch !== e_t || int'(rpt_x) != e_x ||
        int'(rpt_y) != e_y || (!rst && in_ready !== 1'b1)) begin
      errors++;
      $display("FAIL %s model: got v=%b t=%b x=%0d y=%0d rdy=%b exp v=%b t=%b x=%0d y=%0d rdy=1",
               tag, rpt_valid, rpt_touch, rpt_x, rpt_y, in_ready, e_v, e_t, e_x, e_y);
    end
  end

  function automatic logic [31:0] mk(bit pen, int x, int y);
    return {pen, 5'd0, 10'(x), 6'd0, 10'(y)};
  endfunction

  task automatic step(bit v, logic [31:0] w, bit fl, bit ov);
    @(negedge clk);
    in_valid = v; in_word = w; in_flush = fl; in_overrun = ov;
  endtask

  task automatic idle_chk(string r, bit v, bit t, int x, int y);
    step(0, '0, 0, 0);
    checks++;
    if (rpt_valid !== v || rpt_touch !== t || int'(rpt_x) != x || int'(rpt_y) != y) begin
      errors++;
      $display("FAIL %s: got v=%b t=%b x=%0d y=%0d exp v=%b t=%b x=%0d y=%0d",
               r, rpt_valid, rpt_touch, rpt_x, rpt_y, v, t, x, y);
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    checks++;
    if (rpt_valid || rpt_touch || rpt_x != 0 || rpt_y != 0) begin
      errors++;
      $display("FAIL R1: got v=%b t=%b x=%0d y=%0d exp 0 0 0 0", rpt_valid, rpt_touch, rpt_x, rpt_y);
    end
    @(negedge clk); rst = 0;
    idle_chk("R1", 0, 0, 0, 0);
    // R2 R3 R9: full frame, junk in ignored bits, pen up in early words
    tag = "R2";
    step(1, mk(1, 5, 5) | 32'h7C00FC00, 0, 0);
    step(1, mk(1, 100, 0) | 32'h7C00FC00, 0, 0);
    step(1, mk(1, 201, 1023), 0, 0);
    step(1, mk(0, 7, 7), 0, 0);
    idle_chk("R3", 1, 1, 872, 511);
    idle_chk("R7", 0, 1, 872, 511);
    // R4 last sample pen up
    tag = "R4";
    step(1, mk(0, 1, 1), 0, 0);
    step(1, mk(0, 0, 0), 0, 0);
    step(1, mk(0, 0, 0), 0, 0);
    step(1, mk(1, 3, 3), 0, 0);
    idle_chk("R4", 1, 0, 872, 511);
    // R5 short frame flush, and empty flush
    tag = "R5";
    step(1, mk(0, 9, 9), 0, 0);
    step(1, mk(0, 9, 9), 0, 0);
    step(0, '0, 1, 0);
    idle_chk("R5", 1, 0, 872, 511);
    step(0, '0, 1, 0);
    idle_chk("R5", 1, 0, 872, 511);
    // R6 overrun mid-frame, with word and flush in the same cycle
    tag = "R6";
    step(1, mk(0, 0, 0), 0, 0);
    step(1, mk(0, 0, 0), 0, 0);
    step(1, mk(0, 0, 0), 0, 0);
    step(1, mk(0, 0, 0), 1, 1);
    idle_chk("R6", 0, 0, 872, 511);
    step(1, mk(1, 0, 0), 0, 0);
    step(1, mk(0, 1023, 1023), 0, 0);
    step(1, mk(0, 1022, 1023), 0, 0);
    step(1, mk(0, 0, 0), 0, 0);
    idle_chk("R6", 1, 1, 0, 0);
    // R10 word plus flush
    tag = "R10";
    step(1, mk(0, 0, 0), 0, 0);
    step(1, mk(0, 0, 0), 1, 0);
    idle_chk("R10", 1, 0, 0, 0);
    step(1, mk(0, 0, 0), 0, 0);
    step(1, mk(0, 0, 0), 0, 0);
    step(1, mk(0, 0, 0), 0, 0);
    step(1, mk(0, 0, 0), 1, 0);
    idle_chk("R10", 1, 1, 1023, 1023);
    idle_chk("R10", 0, 1, 1023, 1023);
    // R7 R8 random traffic against the model
    tag = "R8";
    for (int i = 0; i < 4000; i++) begin
      int r = $urandom_range(0, 99);
      step(r < 70, $urandom(), r >= 92 && r < 97, r >= 97);
    end
    step(0, '0, 0, 0);
    @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule